// File: doc/BRIEF.md
# Branch Target Prediction Cache with Bulk and Selective Invalidation

This block is a small direct-mapped store of taken-branch targets, looked up with the current fetch address. Each entry has a valid flag, the upper fetch-address bits as a tag, a flag telling whether the branch was recorded in user or supervisor mode, and the branch target. When a fetch address matches a valid entry and predictions are enabled, the block reports a hit and the stored target in the same cycle.

Entries are written when the pipeline reports a resolved taken branch. A correction port removes an entry that predicted wrongly. A three-bit control word sets the enable. The same word also carries two strobes that only act when written as one: one drops every entry, the other drops only the user-mode entries. Both strobes always read back as zero. Any invalidate or push of the instruction cache also empties the whole store.

The valid flags are not reset, so the store's contents are undefined after power-up. Software must write the clear-all strobe before enabling predictions, and it may do both in one control write.

Top module: `btc_store`

## Requirements
- R1: After reset the enable is zero. While the enable is zero, `pred_hit` stays low for every fetch address.
- R2: A control write with bit 1 (clear-all) set invalidates every entry from the next cycle on.
- R3: A control write with bit 2 (clear-user) set invalidates exactly the entries written with `alloc_super`=0. Entries written with `alloc_super`=1 keep hitting with their targets.
- R4: `ctl_rdata` returns the enable in bit 0, and bits 1 and 2 always read zero.
- R5: A control write carrying both clear-all and enable (value 3'b011) leaves the block enabled with every entry invalid in the next cycle.
- R6: A high `icache_inv` at a clock edge invalidates every entry.
- R7: The index is `fetch_pc[IDX_W:1]` and the tag is the bits of `fetch_pc` above the index. A hit requires a valid entry, an equal tag and the enable set, and `pred_target` then equals the stored target. A different tag at the same index misses.
- R8: An `alloc_vld` pulse while the block is enabled writes the tag, the target and the mode into the indexed entry and marks it valid from the next cycle. While the block is disabled, an `alloc_vld` pulse leaves every entry unchanged.
- R9: A `fix_vld` pulse invalidates the entry indexed by `fix_pc` only if its tag matches `fix_pc`. An entry with a different tag keeps hitting.
- R10: In one cycle, clear-all, clear-user or `icache_inv` blocks an allocation. A correction for the same index as an allocation also wins, and the entry ends invalid. An allocation to a different index still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control word: bit0 enable, bit1 clear-all, bit2 clear-user |
| ctl_rdata | output | 3 | Control readback |
| icache_inv | input | 1 | Instruction-cache invalidate or push happened |
| fetch_pc | input | ADDR_W | Fetch address to look up |
| pred_hit | output | 1 | Prediction valid |
| pred_target | output | ADDR_W | Predicted target |
| alloc_vld | input | 1 | Resolved taken branch to record |
| alloc_pc | input | ADDR_W | Address of that branch |
| alloc_target | input | ADDR_W | Its target |
| alloc_super | input | 1 | Branch executed in supervisor mode |
| fix_vld | input | 1 | Misprediction report |
| fix_pc | input | ADDR_W | Address of the mispredicted branch |

## Verification
The bench builds the block with ADDR_W=12 and IDX_W=3, which gives eight entries and 8-bit tags. This size lets every index be filled and looked up after each kind of clear. The bench uses odd indices for supervisor entries and even indices for user entries, and it computes each entry's target arithmetically from its address. This setup exercises the selective clear, the tag-mismatch corrections and the same-cycle priority cases on every entry, not just a sampled few.

// File: rtl/btc_store.sv
module btc_store #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  output logic [2:0]        ctl_rdata,
  input  logic              icache_inv,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              alloc_vld,
  input  logic [ADDR_W-1:0] alloc_pc,
  input  logic [ADDR_W-1:0] alloc_target,
  input  logic              alloc_super,
  input  logic              fix_vld,
  input  logic [ADDR_W-1:0] fix_pc
);
  localparam int N     = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - 1;

  logic              en_q;
  logic [N-1:0]      vld_q, usr_q, vld_nx;
  logic [TAG_W-1:0]  tag_q [N];
  logic [ADDR_W-1:0] tgt_q [N];

  wire [IDX_W-1:0] l_idx = fetch_pc[IDX_W:1];
  wire [IDX_W-1:0] a_idx = alloc_pc[IDX_W:1];
  wire [IDX_W-1:0] f_idx = fix_pc[IDX_W:1];
  wire [TAG_W-1:0] l_tag = fetch_pc[ADDR_W-1:IDX_W+1];
  wire [TAG_W-1:0] a_tag = alloc_pc[ADDR_W-1:IDX_W+1];
  wire [TAG_W-1:0] f_tag = fix_pc[ADDR_W-1:IDX_W+1];

  wire clr_all   = (ctl_wr && ctl_wdata[1]) || icache_inv;
  wire clr_user  = ctl_wr && ctl_wdata[2];
  wire alloc_go  = alloc_vld && en_q && !clr_all && !clr_user;
  wire fix_match = fix_vld && vld_q[f_idx] && (tag_q[f_idx] == f_tag);

  assign ctl_rdata   = {2'b00, en_q};
  assign pred_hit    = en_q && vld_q[l_idx] && (tag_q[l_idx] == l_tag);
  assign pred_target = tgt_q[l_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      en_q <= 1'b0;
    else if (ctl_wr) en_q <= ctl_wdata[0];

  always_comb begin
    vld_nx = vld_q;
    if (alloc_go)  vld_nx[a_idx] = 1'b1;
    if (fix_match) vld_nx[f_idx] = 1'b0;
    if (clr_user)  vld_nx = vld_nx & ~usr_q;
    if (clr_all)   vld_nx = '0;
  end

  always_ff @(posedge clk) vld_q <= vld_nx;

  always_ff @(posedge clk)
    if (alloc_go) begin
      tag_q[a_idx] <= a_tag;
      tgt_q[a_idx] <= alloc_target;
      usr_q[a_idx] <= !alloc_super;
    end

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[0] |-> !pred_hit); // R1
  AST_CLR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1]) |=> (vld_q == '0)); // R2
  AST_CLR_USER_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[2]) |=> ((vld_q & usr_q) == '0)); // R3
  AST_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    icache_inv |=> (vld_q == '0)); // R6
  AST_ALLOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && ctl_rdata[0] && !ctl_wr && !icache_inv && !(fix_vld && f_idx == a_idx))
    |=> vld_q[$past(a_idx)]); // R8
  AST_FIX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_vld && vld_q[f_idx] && tag_q[f_idx] == f_tag) |=> !vld_q[$past(f_idx)]); // R9
endmodule

// File: tb/btc_store_bench.sv
module btc_store_bench;
  localparam int AW = 12;
  localparam int IW = 3;
  localparam int NE = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0;
  logic [2:0] ctl_wdata = 0, ctl_rdata;
  logic icache_inv = 0;
  logic [AW-1:0] fetch_pc = 0, pred_target, alloc_pc = 0, alloc_target = 0, fix_pc = 0;
  logic pred_hit, alloc_vld = 0, alloc_super = 0, fix_vld = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btc_store #(.ADDR_W(AW), .IDX_W(IW)) u_btc_store (.*);

  function automatic logic [AW-1:0] pc_of(int tag, int idx);
    return AW'((tag << (IW + 1)) | (idx << 1));
  endfunction
  function automatic logic [AW-1:0] tgt_of(logic [AW-1:0] pc);
    return AW'((pc * 5 + 12'h030) & 12'hffe);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(logic [2:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic alloc(logic [AW-1:0] pc, logic sup);
    @(negedge clk); alloc_vld = 1; alloc_pc = pc; alloc_target = tgt_of(pc); alloc_super = sup;
    @(negedge clk); alloc_vld = 0;
  endtask

  task automatic fix(logic [AW-1:0] pc);
    @(negedge clk); fix_vld = 1; fix_pc = pc;
    @(negedge clk); fix_vld = 0;
  endtask

  task automatic look(logic [AW-1:0] pc, bit exp_hit, string req);
    fetch_pc = pc; #2;
    chk(pred_hit == exp_hit, req, int'(pred_hit), int'(exp_hit));
    if (exp_hit) chk(pred_target == tgt_of(pc), req, int'(pred_target), int'(tgt_of(pc)));
  endtask

  task automatic fill(int tag);
    for (int i = 0; i < NE; i++) alloc(pc_of(tag, i), i[0]);
  endtask

  initial begin
    #45 rst_n = 1;
    @(negedge clk);
    chk(ctl_rdata == 3'b000, "R4 reset", int'(ctl_rdata), 0);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 0, "R1 reset off");

    ctl(3'b011);
    chk(ctl_rdata == 3'b001, "R4 readback", int'(ctl_rdata), 1);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 0, "R5 clear+enable");

    fill(5);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 1, "R8 R7 hit");
    for (int i = 0; i < NE; i++) look(pc_of(6, i), 0, "R7 tag miss");

    ctl(3'b000);
    chk(ctl_rdata == 3'b000, "R4 off", int'(ctl_rdata), 0);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 0, "R1 off");
    alloc(pc_of(7, 0), 1);
    ctl(3'b001);
    look(pc_of(5, 0), 1, "R8 disabled alloc ignored");
    look(pc_of(7, 0), 0, "R8 disabled alloc ignored");

    fix(pc_of(9, 2));
    look(pc_of(5, 2), 1, "R9 tag mismatch kept");
    fix(pc_of(5, 2));
    look(pc_of(5, 2), 0, "R9 fix dropped");
    look(pc_of(5, 3), 1, "R9 neighbour kept");

    fill(5);
    ctl(3'b101);
    chk(ctl_rdata == 3'b001, "R4 clear-user reads 0", int'(ctl_rdata), 1);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), i[0], "R3 clear user");

    fill(5);
    @(negedge clk); icache_inv = 1;
    @(negedge clk); icache_inv = 0;
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 0, "R6 icache inv");

    fill(5);
    ctl(3'b001);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 1, "R8 refill");
    ctl(3'b011);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 0, "R2 clear all");

    fill(5);
    ctl(3'b000);
    ctl(3'b011);
    for (int i = 0; i < NE; i++) look(pc_of(5, i), 0, "R5 clear+enable from off");

    @(negedge clk); ctl_wr = 1; ctl_wdata = 3'b011;
    alloc_vld = 1; alloc_pc = pc_of(3, 1); alloc_target = tgt_of(pc_of(3, 1)); alloc_super = 1;
    @(negedge clk); ctl_wr = 0; alloc_vld = 0;
    look(pc_of(3, 1), 0, "R10 clear beats alloc");

    @(negedge clk); icache_inv = 1;
    alloc_vld = 1; alloc_pc = pc_of(3, 4); alloc_target = tgt_of(pc_of(3, 4)); alloc_super = 1;
    @(negedge clk); icache_inv = 0; alloc_vld = 0;
    look(pc_of(3, 4), 0, "R10 inv beats alloc");

    alloc(pc_of(4, 6), 1);
    @(negedge clk);
    alloc_vld = 1; alloc_pc = pc_of(8, 6); alloc_target = tgt_of(pc_of(8, 6)); alloc_super = 1;
    fix_vld = 1; fix_pc = pc_of(4, 6);
    @(negedge clk); alloc_vld = 0; fix_vld = 0;
    look(pc_of(8, 6), 0, "R10 fix beats alloc same index");
    look(pc_of(4, 6), 0, "R10 fix beats alloc same index");

    alloc(pc_of(4, 5), 1);
    @(negedge clk);
    alloc_vld = 1; alloc_pc = pc_of(2, 7); alloc_target = tgt_of(pc_of(2, 7)); alloc_super = 0;
    fix_vld = 1; fix_pc = pc_of(4, 5);
    @(negedge clk); alloc_vld = 0; fix_vld = 0;
    look(pc_of(2, 7), 1, "R10 alloc other index");
    look(pc_of(4, 5), 0, "R10 fix other index");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule